// File: doc/BRIEF.md
# Time-Multiplexed Output Compare Array

This block drives a large number of 16-bit output-compare channels from one shared datapath. No channel has a counter of its own: each channel's running phase sits in block RAM, and a short sweep after every timer tick reads all the phases, steps them, writes them back and refreshes each channel's output level. The timer tick comes from a prescaler that divides the system clock (by 64 by default). Channels are grouped into banks. Each bank holds a number of left/right pairs. In every sweep step each bank advances four channels together: an even and an odd pair, on both the left and the right side.

A host writes a channel's high-time and low-time, both counted in ticks, through a simple write port. A channel produces a periodic pulse train: high for the high-time, then low for the low-time. Writing a zero for either value turns the channel off. The levels of all left channels are ORed into one registered left output, and the right channels are ORed into one registered right output. The usual client is a multi-note pulse generator whose pulses are merged onto one line per side.

Top module: `ocmp_array`

## Requirements
- R1: The timer tick fires every PRESCALE clock cycles. The first tick falls on the PRESCALE-th rising edge after reset is released. A channel at pair index 0 shows its new level on its side output at the fourth rising edge after its tick edge.
- R2: Every channel in every bank is updated once per tick. The sweep finishes, and the outputs show the state of that tick, before the next tick arrives.
- R3: An enabled channel with high-time H and low-time L is high for H consecutive ticks and then low for L ticks, and repeats with period H+L ticks.
- R4: A channel whose high-time or low-time is zero is disabled, and its level stays low for as long as that holds.
- R5: A host write to a channel restarts that channel's phase. On the next tick the channel begins a fresh high period, even if it was in the middle of a cycle.
- R6: out_left is the OR of the levels of all left-side channels across all banks. out_right is the OR of all right-side channels. The two sides never affect each other.
- R7: After reset every channel is disabled and both outputs are low.
- R8: A host write selects exactly one channel, by host_bank, host_pair (0 to PAIRS_PER_BANK-1) and host_side (0 = left, 1 = right). No other channel's values or phase change.
- R9: A channel with high-time 1 and low-time 1 toggles its level on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for one channel's compare values |
| host_bank | input | BW | Bank index of the written channel |
| host_pair | input | PIW | Pair index within the bank |
| host_side | input | 1 | 0 selects the left channel, 1 the right channel |
| host_on | input | CNT_W | High-time in ticks |
| host_off | input | CNT_W | Low-time in ticks |
| out_left | output | 1 | Registered OR of all left-channel levels |
| out_right | output | 1 | Registered OR of all right-channel levels |

## Verification
Each channel's state lives in RAM and flop arrays and reaches the pins only through the two wide ORs. A wrong phase, a missing restart or a stale enable therefore shows up as a wrong level on one side output, and it shows up in the same tick period the fault affects. The bench enables a few channels at a time, so a single bad channel changes the ORed result. It compares both outputs after every sweep against a tick-level model. Sweep timing faults show up within the first tick, through the edge-exact check on pair 0.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int CNT_W_DEF    = 16;
  localparam int PRESCALE_DEF = 64;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/ocmp_sdp_ram.sv
// Simple dual-port RAM, one write port and one synchronous read port, read-first.
module ocmp_sdp_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler #(
  parameter int PRESCALE = 64,
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (div_q == PW'(PRESCALE - 1));
      div_q <= (div_q == PW'(PRESCALE - 1)) ? '0 : div_q + 1'b1;
    end
  end

  // R1: ticks are isolated single-cycle pulses
  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ocmp_sweep.sv
// Walks the lane address space once per tick; stage-1 strobes follow one cycle later.
module ocmp_sweep #(
  parameter int STEPS = 32,
  localparam int AW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr
);
  logic          busy_q;
  logic [AW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      wb_en   <= 1'b0;
      wb_addr <= '0;
    end else begin
      wb_en   <= busy_q;
      wb_addr <= step_q;
      if (tick && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        if (step_q == AW'(STEPS - 1)) busy_q <= 1'b0;
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign rd_en   = busy_q;
  assign rd_addr = step_q;

  // R2: a new tick never arrives while the previous sweep is still running
  a_r2_sweep_fits: assert property (@(posedge clk) disable iff (rst)
    tick |-> !busy_q);
endmodule

// File: rtl/ocmp_lane.sv
// One stream of channels (one bank, one side, one parity): config RAM, phase RAM, level flops.
module ocmp_lane #(
  parameter int DEPTH = 32,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_on,
  input  logic [CW-1:0] wr_off,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  output logic          any_hi
);
  logic [DEPTH-1:0] en_q, dirty_q, lvl_q;
  logic             en_s1, dirty_s1;
  logic [2*CW-1:0]  cfg_rd;
  logic [CW-1:0]    cnt_rd, nxt_cnt, cfg_on, cfg_off;
  logic [CW:0]      period, inc;
  logic             nxt_lvl;

  ocmp_sdp_ram #(.W(2*CW), .DEPTH(DEPTH)) u_cfg (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({wr_on, wr_off}),
    .raddr(rd_addr), .rdata(cfg_rd));

  ocmp_sdp_ram #(.W(CW), .DEPTH(DEPTH)) u_cnt (
    .clk(clk), .we(wb_en), .waddr(wb_addr), .wdata(nxt_cnt),
    .raddr(rd_addr), .rdata(cnt_rd));

  assign cfg_on  = cfg_rd[2*CW-1:CW];
  assign cfg_off = cfg_rd[CW-1:0];

  always_comb begin
    period  = {1'b0, cfg_on} + {1'b0, cfg_off};
    inc     = {1'b0, cnt_rd} + 1'b1;
    nxt_cnt = '0;
    nxt_lvl = 1'b0;
    if (en_s1) begin
      if (!dirty_s1 && (inc < period)) nxt_cnt = inc[CW-1:0];
      nxt_lvl = (nxt_cnt < cfg_on);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      dirty_q  <= '0;
      lvl_q    <= '0;
      en_s1    <= 1'b0;
      dirty_s1 <= 1'b0;
    end else begin
      if (rd_en) begin
        en_s1            <= en_q[rd_addr];
        dirty_s1         <= dirty_q[rd_addr];
        dirty_q[rd_addr] <= 1'b0;
      end
      if (wr_en) begin
        en_q[wr_addr]    <= (wr_on != '0) && (wr_off != '0);
        dirty_q[wr_addr] <= 1'b1;
      end
      if (wb_en) lvl_q[wb_addr] <= nxt_lvl;
    end
  end

  assign any_hi = |lvl_q;

  // R4: a disabled channel always ends its update low
  a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !en_s1) |=> !lvl_q[$past(wb_addr)]);

  // R5: a restarted enabled channel opens with a high level
  a_r5_restart_high: assert property (@(posedge clk) disable iff (rst)
    (wb_en && en_s1 && dirty_s1) |=> lvl_q[$past(wb_addr)]);
endmodule

// File: rtl/ocmp_array.sv
module ocmp_array #(
  parameter int NUM_BANKS      = 4,
  parameter int PAIRS_PER_BANK = 64,
  parameter int CNT_W          = ocmp_pkg::CNT_W_DEF,
  parameter int PRESCALE       = ocmp_pkg::PRESCALE_DEF,
  localparam int BW            = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PIW           = $clog2(PAIRS_PER_BANK),
  localparam int STEPS         = PAIRS_PER_BANK / 2,
  localparam int LAW           = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [BW-1:0]    host_bank,
  input  logic [PIW-1:0]   host_pair,
  input  logic             host_side,
  input  logic [CNT_W-1:0] host_on,
  input  logic [CNT_W-1:0] host_off,
  output logic             out_left,
  output logic             out_right
);
  import ocmp_pkg::*;

  if (PRESCALE < STEPS + 4) begin : g_budget_err
    $error("ocmp_array: PRESCALE too small for the sweep length");
  end

  logic           tick;
  logic           rd_en, wb_en;
  logic [LAW-1:0] rd_addr, wb_addr;
  logic [2*NUM_BANKS-1:0] lane_hi [2];

  ocmp_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst(rst), .tick(tick));

  ocmp_sweep #(.STEPS(STEPS)) u_sweep (
    .clk(clk), .rst(rst), .tick(tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .wb_en(wb_en), .wb_addr(wb_addr));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < 2; s++) begin : g_side
      for (genvar q = 0; q < 2; q++) begin : g_par
        logic sel;
        assign sel = host_we
                   && (host_bank == BW'(b))
                   && (host_side == ((s == 1) ? SIDE_RIGHT : SIDE_LEFT))
                   && (host_pair[0] == 1'(q));
        ocmp_lane #(.DEPTH(STEPS), .CW(CNT_W)) u_lane (
          .clk(clk), .rst(rst),
          .wr_en(sel), .wr_addr(host_pair[PIW-1:1]),
          .wr_on(host_on), .wr_off(host_off),
          .rd_en(rd_en), .rd_addr(rd_addr),
          .wb_en(wb_en), .wb_addr(wb_addr),
          .any_hi(lane_hi[s][b*2+q]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_left  <= 1'b0;
      out_right <= 1'b0;
    end else begin
      out_left  <= |lane_hi[0];
      out_right <= |lane_hi[1];
    end
  end
endmodule

// File: tb/ocmp_array_test.sv
module ocmp_array_test;
  localparam int NB   = 2;
  localparam int NP   = 8;
  localparam int CW   = 16;
  localparam int P    = 16;
  localparam int NCH  = NB * NP * 2;
  localparam int BW   = 1;
  localparam int PIW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [BW-1:0]  host_bank = '0;
  logic [PIW-1:0] host_pair = '0;
  logic host_side = 1'b0;
  logic [CW-1:0] host_on = '0, host_off = '0;
  logic out_left, out_right;

  ocmp_array #(.NUM_BANKS(NB), .PAIRS_PER_BANK(NP), .CNT_W(CW), .PRESCALE(P)) uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_bank(host_bank),
    .host_pair(host_pair), .host_side(host_side), .host_on(host_on),
    .host_off(host_off), .out_left(out_left), .out_right(out_right));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, edge_now = 0, k = 0;
  bit done = 0;
  int m_on [NCH], m_off [NCH], m_ph [NCH];
  bit m_dirty [NCH], m_lv [NCH];

  function automatic int chi(int b, int p, int s);
    return (b * NP + p) * 2 + s;
  endfunction

  function automatic bit exp_side(int s);
    bit r = 0;
    for (int c = s; c < NCH; c += 2) r |= m_lv[c];
    return r;
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s tick=%0d actual=%0b expected=%0b", tag, what, k, act, exp);
    end
  endtask

  task automatic goto(int target);
    while (edge_now < target) begin
      @(posedge clk); edge_now++; @(negedge clk);
    end
  endtask

  task automatic model_tick();
    for (int c = 0; c < NCH; c++) begin
      if (m_on[c] == 0 || m_off[c] == 0) begin
        m_ph[c] = 0; m_lv[c] = 0;
      end else begin
        if (m_dirty[c] || (m_ph[c] + 1 >= m_on[c] + m_off[c])) m_ph[c] = 0;
        else m_ph[c] = m_ph[c] + 1;
        m_lv[c] = (m_ph[c] < m_on[c]);
      end
      m_dirty[c] = 0;
    end
  endtask

  task automatic run_tick(string tag, bit wr, int b, int p, int s, int on, int off);
    goto(k * P + P - 1);
    chk(tag, "out_left", out_left, exp_side(0));
    chk(tag, "out_right", out_right, exp_side(1));
    if (wr) begin
      host_we = 1; host_bank = BW'(b); host_pair = PIW'(p); host_side = s[0];
      host_on = CW'(on); host_off = CW'(off);
      m_on[chi(b,p,s)] = on; m_off[chi(b,p,s)] = off; m_dirty[chi(b,p,s)] = 1;
      @(posedge clk); edge_now++; @(negedge clk);
      host_we = 0;
    end
    model_tick();
    k++;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_on[c] = 0; m_off[c] = 0; m_ph[c] = 0; m_dirty[c] = 0; m_lv[c] = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R7: reset state
    chk("R7", "out_left", out_left, 1'b0);
    chk("R7", "out_right", out_right, 1'b0);
    run_tick("R7", 1, 0, 0, 0, 3, 2);
    // R1: pair 0 appears exactly four edges after the first tick
    goto(P + 3);
    chk("R1", "out_left early", out_left, 1'b0);
    goto(P + 4);
    chk("R1", "out_left on time", out_left, 1'b1);
    for (int i = 0; i < 9; i++) run_tick("R3", 0, 0, 0, 0, 0, 0);
    run_tick("R4", 1, 0, 0, 0, 0, 5);
    for (int i = 0; i < 2; i++) run_tick("R4", 0, 0, 0, 0, 0, 0);
    run_tick("R4", 1, 0, 0, 0, 4, 0);
    for (int i = 0; i < 2; i++) run_tick("R4", 0, 0, 0, 0, 0, 0);
    run_tick("R9", 1, NB - 1, NP - 1, 1, 1, 1);
    for (int i = 0; i < 5; i++) run_tick("R9", 0, 0, 0, 0, 0, 0);
    run_tick("R8", 1, 0, 0, 0, 2, 3);
    for (int i = 0; i < 3; i++) run_tick("R8", 0, 0, 0, 0, 0, 0);
    run_tick("R5", 1, 0, 0, 0, 2, 3);
    for (int i = 0; i < 4; i++) run_tick("R5", 0, 0, 0, 0, 0, 0);
    run_tick("R6", 1, 0, 0, 0, 0, 0);
    run_tick("R6", 1, 1, 3, 0, 5, 5);
    for (int i = 0; i < 12; i++) run_tick("R6", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      bit wr = ($urandom % 3) == 0;
      int b = int'($urandom % NB), p = int'($urandom % NP), s = int'($urandom % 2);
      int on = int'($urandom % 7), off = int'($urandom % 7);
      if (($urandom % 25) == 0) on = 16'hFFFF;
      run_tick("R2", wr, b, p, s, on, off);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule